// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Controller

This block decides where each ALU operand of a five-stage in-order integer pipeline comes from. Its pipeline runs fetch, decode, execute, memory and writeback. The decode-stage instruction names up to two source registers. Each source has a flag that says whether the instruction reads it. The block compares each source against the destination register of every older instruction still in flight. It then returns a 2-bit select per operand that picks one of four values: the register file value, the execute-stage result, the memory-stage ALU result, or the data a load has just read.

Forwarding covers a value produced one instruction ahead, as long as that producer is not a load. A load followed at once by a consumer of its result cannot be served in time. For that case the block raises a hold for the PC and the decode register, and in the same cycle asks for a bubble in execute. The bubble must act as a nop. In the next cycle the load sits in the memory stage and the waiting instruction takes its data from there.

The register file writes early in a cycle and reads late in the same cycle. Because of this, a producer in writeback needs no bypass path. Register 0 is hard-wired and never counts as a producer.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A destination of register 0 never causes a forward or a stall. A source naming register 0 always gets select 2'b00.
- R2: If a used source matches the destination of a non-load instruction in execute that has write enable set, that operand gets select 2'b01 (execute result).
- R3: If a used source matches a writing instruction in the memory stage, and no execute producer matches, the select is 2'b10 (memory-stage ALU result) when that instruction is not a load. It is 2'b11 (load data) when it is a load.
- R4: If execute and memory both write the same matching register, the younger producer in execute wins.
- R5: A match with only the writeback stage gives select 2'b00, because the register file already returns the new value.
- R6: A source whose use flag is low gets select 2'b00 and never causes a stall.
- R7: If the execute instruction is a load with a nonzero destination that matches a used source, both hold_fd and bubble_x are 1 in that cycle, and both selects are 2'b00.
- R8: Once the requested bubble is in execute and the load has moved to memory, the stall drops. The dependent operand then gets select 2'b11.
- R9: The two operands are resolved independently and may carry different selects in the same cycle.
- R10: A producer whose write enable is low is ignored in every stage.
- R11: While rst_n is low, both selects are 2'b00 and hold_fd and bubble_x are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_rs1 | input | 5 | First source register of the decode instruction |
| d_rs1_use | input | 1 | Decode instruction reads its first source |
| d_rs2 | input | 5 | Second source register of the decode instruction |
| d_rs2_use | input | 1 | Decode instruction reads its second source |
| x_rd | input | 5 | Destination register of the execute instruction |
| x_we | input | 1 | Execute instruction writes a register |
| x_load | input | 1 | Execute instruction is a load |
| m_rd | input | 5 | Destination register of the memory-stage instruction |
| m_we | input | 1 | Memory-stage instruction writes a register |
| m_load | input | 1 | Memory-stage instruction is a load |
| w_rd | input | 5 | Destination register of the writeback instruction |
| w_we | input | 1 | Writeback instruction writes a register |
| fwd_sel_a | output | 2 | Select for the first ALU operand |
| fwd_sel_b | output | 2 | Select for the second ALU operand |
| hold_fd | output | 1 | Freeze the PC and the decode register |
| bubble_x | output | 1 | Replace the next execute entry with a nop |

## Verification
Several rules are checked by assertions on every cycle. A zero source always reads the register file. An unused source never forwards. A load-data select is only given when a load sits in memory, and execute wins over memory. A writeback-only match falls back to the register file. A stall always has a load producer in execute, and it forces both selects to the register file. A stall cannot repeat once a bubble occupies execute. Other behaviour only shows up in the bench's pipeline scenarios, which shift instructions through a model of the stages: that a load-use pair costs exactly one cycle, that the waiting instruction then takes the load data, and that the reset outputs are correct.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_EX  = 2'b01,
        FWD_MEM = 2'b10,
        FWD_LD  = 2'b11
    } fwd_sel_e;

    typedef struct packed {
        logic stall_prev;
    } hzd_state_t;

endpackage

// File: rtl/hzd_stage_match.sv
module hzd_stage_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              src_use,
    input  logic [REG_AW-1:0] dst,
    input  logic              dst_we,
    output logic              hit
);
    // register 0 is constant and never a producer
    always_comb begin
        hit = src_use && dst_we && (dst != '0) && (dst == src);
    end
endmodule

// File: rtl/hzd_src_sel.sv
module hzd_src_sel
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] src,
    input  logic              src_use,
    input  logic [REG_AW-1:0] x_dst,
    input  logic              x_we,
    input  logic              x_load,
    input  logic [REG_AW-1:0] m_dst,
    input  logic              m_we,
    input  logic              m_load,
    input  logic [REG_AW-1:0] w_dst,
    input  logic              w_we,
    output logic [1:0]        sel,
    output logic              ld_hit
);
    localparam int NSTG = 3;
    localparam int STG_X = 0;
    localparam int STG_M = 1;
    localparam int STG_W = 2;

    logic [NSTG-1:0][REG_AW-1:0] dst_v;
    logic [NSTG-1:0]             we_v;
    logic [NSTG-1:0]             hit_v;

    always_comb begin
        dst_v[STG_X] = x_dst;
        dst_v[STG_M] = m_dst;
        dst_v[STG_W] = w_dst;
        we_v[STG_X]  = x_we;
        we_v[STG_M]  = m_we;
        we_v[STG_W]  = w_we;
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        hzd_stage_match #(.REG_AW(REG_AW)) u_match (
            .src     (src),
            .src_use (src_use),
            .dst     (dst_v[g]),
            .dst_we  (we_v[g]),
            .hit     (hit_v[g])
        );
    end

    // youngest producer first; writeback is covered by the split-phase file
    always_comb begin
        ld_hit = hit_v[STG_X] && x_load;
        if (hit_v[STG_X]) begin
            sel = x_load ? FWD_RF : FWD_EX;
        end else if (hit_v[STG_M]) begin
            sel = m_load ? FWD_LD : FWD_MEM;
        end else begin
            sel = FWD_RF;
        end
    end

    AST_ZERO_SRC_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == FWD_RF && !ld_hit)); // R1
    AST_IDLE_SRC_RF: assert property (@(posedge clk) disable iff (!rst_n)
        !src_use |-> (sel == FWD_RF && !ld_hit)); // R6
    AST_LD_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_LD) |-> (m_load && m_we && m_dst == src)); // R3
    AST_EX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[STG_X] && hit_v[STG_M] && !x_load) |-> (sel == FWD_EX)); // R4
    AST_WB_ONLY_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v[STG_W] && !hit_v[STG_X] && !hit_v[STG_M]) |-> (sel == FWD_RF)); // R5

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import hzd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] d_rs1,
    input  logic              d_rs1_use,
    input  logic [REG_AW-1:0] d_rs2,
    input  logic              d_rs2_use,
    input  logic [REG_AW-1:0] x_rd,
    input  logic              x_we,
    input  logic              x_load,
    input  logic [REG_AW-1:0] m_rd,
    input  logic              m_we,
    input  logic              m_load,
    input  logic [REG_AW-1:0] w_rd,
    input  logic              w_we,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              hold_fd,
    output logic              bubble_x
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] src_v;
    logic [NSRC-1:0]             use_v;
    logic [NSRC-1:0][1:0]        sel_v;
    logic [NSRC-1:0]             ld_hit_v;
    logic                        stall;

    hzd_state_t state_d, state_q;

    always_comb begin
        src_v[0] = d_rs1;
        src_v[1] = d_rs2;
        use_v[0] = d_rs1_use;
        use_v[1] = d_rs2_use;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        hzd_src_sel #(.REG_AW(REG_AW)) u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_v[s]),
            .src_use (use_v[s]),
            .x_dst   (x_rd),
            .x_we    (x_we),
            .x_load  (x_load),
            .m_dst   (m_rd),
            .m_we    (m_we),
            .m_load  (m_load),
            .w_dst   (w_rd),
            .w_we    (w_we),
            .sel     (sel_v[s]),
            .ld_hit  (ld_hit_v[s])
        );
    end

    always_comb begin
        stall              = rst_n && (|ld_hit_v);
        state_d            = state_q;
        state_d.stall_prev = stall;
        if (!rst_n || stall) begin
            fwd_sel_a = FWD_RF;
            fwd_sel_b = FWD_RF;
        end else begin
            fwd_sel_a = sel_v[0];
            fwd_sel_b = sel_v[1];
        end
        hold_fd  = stall;
        bubble_x = stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_fd |-> (x_we && x_load && x_rd != '0)); // R7
    AST_STALL_SELS_RF: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_x |-> (fwd_sel_a == FWD_RF && fwd_sel_b == FWD_RF)); // R7
    AST_ONE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.stall_prev && !x_we) |-> !hold_fd); // R8
    AST_NO_WRITERS_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_we && !m_we) |-> (fwd_sel_a == FWD_RF && fwd_sel_b == FWD_RF && !hold_fd)); // R10

endmodule

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] d_rs1, d_rs2, x_rd, m_rd, w_rd;
    logic       d_rs1_use, d_rs2_use, x_we, x_load, m_we, m_load, w_we;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       hold_fd, bubble_x;

    always #5 clk = ~clk;

    hazard_fwd_unit u_hazard_fwd_unit (
        .clk(clk), .rst_n(rst_n),
        .d_rs1(d_rs1), .d_rs1_use(d_rs1_use), .d_rs2(d_rs2), .d_rs2_use(d_rs2_use),
        .x_rd(x_rd), .x_we(x_we), .x_load(x_load),
        .m_rd(m_rd), .m_we(m_we), .m_load(m_load),
        .w_rd(w_rd), .w_we(w_we),
        .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b),
        .hold_fd(hold_fd), .bubble_x(bubble_x)
    );

    typedef struct {
        logic [4:0] rs1; logic u1; logic [4:0] rs2; logic u2;
        logic [4:0] rd;  logic we; logic ld;  string tag;
    } ins_t;

    typedef struct {
        logic [1:0] a; logic [1:0] b; logic stall; string tag;
    } exp_t;

    exp_t sb[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;
    bit   prev_stall = 0;
    ins_t st_d, st_x, st_m, st_w;

    function automatic ins_t mk(logic [4:0] rs1, logic u1, logic [4:0] rs2, logic u2,
                                logic [4:0] rd, logic we, logic ld, string tag);
        ins_t i;
        i.rs1 = rs1; i.u1 = u1; i.rs2 = rs2; i.u2 = u2;
        i.rd = rd; i.we = we; i.ld = ld; i.tag = tag;
        return i;
    endfunction

    function automatic ins_t nop();
        return mk(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, "R6");
    endfunction

    // reference: R1 zero, R6 use, R10 we, R2/R4 execute first, R3 memory, R5 wb -> file
    function automatic logic [1:0] ref_sel(logic [4:0] rs, logic u);
        if (!u || rs == 5'd0) return 2'b00;
        if (st_x.we && st_x.rd == rs) return st_x.ld ? 2'b00 : 2'b01;
        if (st_m.we && st_m.rd == rs) return st_m.ld ? 2'b11 : 2'b10;
        return 2'b00;
    endfunction

    function automatic logic ref_stall();
        if (!(st_x.ld && st_x.we && st_x.rd != 5'd0)) return 1'b0;
        return (st_d.u1 && st_d.rs1 == st_x.rd) || (st_d.u2 && st_d.rs2 == st_x.rd);
    endfunction

    // driver: one cycle of stage contents, expected outputs into the scoreboard
    task automatic drive_cycle(output logic stl);
        exp_t e;
        @(negedge clk);
        d_rs1 = st_d.rs1; d_rs1_use = st_d.u1; d_rs2 = st_d.rs2; d_rs2_use = st_d.u2;
        x_rd = st_x.rd; x_we = st_x.we; x_load = st_x.ld;
        m_rd = st_m.rd; m_we = st_m.we; m_load = st_m.ld;
        w_rd = st_w.rd; w_we = st_w.we;
        stl = ref_stall();
        e.stall = stl;
        e.a = stl ? 2'b00 : ref_sel(st_d.rs1, st_d.u1);
        e.b = stl ? 2'b00 : ref_sel(st_d.rs2, st_d.u2);
        if (stl)             e.tag = "R7";
        else if (prev_stall) e.tag = "R8";
        else                 e.tag = st_d.tag;
        sb.push_back(e);
        prev_stall = stl;
    endtask

    task automatic issue(ins_t i);
        logic stl;
        st_d = i;
        do begin
            drive_cycle(stl);
            st_w = st_m;
            st_m = st_x;
            st_x = stl ? nop() : st_d;
        end while (stl);
    endtask

    // monitor: pops scoreboard away from the clock edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_run++;
                if (fwd_sel_a !== e.a || fwd_sel_b !== e.b ||
                    hold_fd !== e.stall || bubble_x !== e.stall) begin
                    n_fail++;
                    $display("FAIL %s: got sel_a=%0d sel_b=%0d hold=%0b bubble=%0b, expected sel_a=%0d sel_b=%0d stall=%0b",
                             e.tag, fwd_sel_a, fwd_sel_b, hold_fd, bubble_x, e.a, e.b, e.stall);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t e;
        rst_n = 1'b0;
        st_d = nop(); st_x = nop(); st_m = nop(); st_w = nop();
        // R11: load-use inputs while in reset must stay quiet
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            d_rs1 = 5'd3; d_rs1_use = 1'b1; d_rs2 = 5'd4; d_rs2_use = 1'b1;
            x_rd = 5'd3; x_we = 1'b1; x_load = 1'b1;
            m_rd = 5'd4; m_we = 1'b1; m_load = 1'b0;
            w_rd = 5'd0; w_we = 1'b0;
            e.a = 2'b00; e.b = 2'b00; e.stall = 1'b0; e.tag = "R11";
            sb.push_back(e);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) issue(nop());

        issue(mk(5'd1, 1, 5'd2, 1, 5'd5, 1, 0, "R2"));
        issue(mk(5'd5, 1, 5'd0, 0, 5'd7, 1, 0, "R2"));   // x5 from execute -> 01
        issue(mk(5'd6, 1, 5'd5, 1, 5'd8, 1, 0, "R3"));   // x5 from memory -> 10
        issue(mk(5'd5, 1, 5'd7, 1, 5'd0, 0, 0, "R5"));   // x5 only in wb -> 00, x7 mem -> 10
        issue(mk(5'd1, 1, 5'd1, 1, 5'd9, 1, 0, "R4"));
        issue(mk(5'd2, 1, 5'd2, 1, 5'd9, 1, 0, "R4"));
        issue(mk(5'd9, 1, 5'd9, 1, 5'd10, 1, 0, "R4"));  // both in x and m -> 01
        issue(mk(5'd1, 1, 5'd2, 1, 5'd0, 1, 0, "R1"));   // writes x0
        issue(mk(5'd0, 1, 5'd0, 1, 5'd13, 1, 0, "R1"));  // reads x0 -> 00
        issue(mk(5'd1, 1, 5'd2, 1, 5'd11, 0, 0, "R10")); // no write enable
        issue(mk(5'd11, 1, 5'd11, 1, 5'd0, 0, 0, "R10"));
        issue(mk(5'd1, 1, 5'd2, 1, 5'd12, 1, 0, "R6"));
        issue(mk(5'd12, 0, 5'd12, 1, 5'd0, 0, 0, "R6")); // a unused -> 00, b -> 01
        issue(mk(5'd1, 1, 5'd2, 1, 5'd15, 1, 0, "R9"));
        issue(mk(5'd1, 1, 5'd2, 1, 5'd16, 1, 0, "R9"));
        issue(mk(5'd15, 1, 5'd16, 1, 5'd0, 0, 0, "R9")); // a mem 10, b ex 01
        issue(mk(5'd1, 0, 5'd2, 0, 5'd14, 1, 1, "R7"));  // load x14
        issue(mk(5'd14, 1, 5'd3, 1, 5'd0, 0, 0, "R7"));  // stall, then 11
        issue(mk(5'd1, 0, 5'd2, 0, 5'd21, 1, 1, "R7"));  // load x21
        issue(mk(5'd4, 1, 5'd21, 1, 5'd0, 0, 0, "R7"));  // stall on rs2, then 11
        issue(mk(5'd1, 0, 5'd2, 0, 5'd0, 1, 1, "R1"));   // load to x0
        issue(mk(5'd0, 1, 5'd0, 1, 5'd0, 0, 0, "R1"));   // no stall
        issue(mk(5'd1, 0, 5'd2, 0, 5'd17, 1, 1, "R3"));  // load x17
        issue(mk(5'd1, 1, 5'd2, 1, 5'd18, 1, 0, "R3"));
        issue(mk(5'd17, 1, 5'd18, 1, 5'd0, 0, 0, "R3")); // a load data 11, b ex 01
        issue(mk(5'd1, 0, 5'd2, 0, 5'd20, 1, 1, "R6"));  // load x20
        issue(mk(5'd20, 0, 5'd20, 0, 5'd0, 0, 0, "R6")); // unused: no stall
        for (int k = 0; k < 3; k++) issue(nop());

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule